// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block collects 64 level-sensitive interrupt request lines and presents one winning request to the processor as a priority level and a vector number. Each source has a pending bit that tracks its input line, a mask bit and an 8-bit level register. A source can win only when it is requesting, enabled and unmasked. A nonzero level both enables a source and sets its priority.

Software reaches the controller through a simple 32-bit register bus with byte offsets. Through it, software programs the per-source levels, reads or writes the 64-bit mask as two halves, and sets or clears one mask bit (or all of them) with a single byte command. It can also read the pending bits and the vector that is currently presented. Among the active sources the highest level wins, and on equal levels the higher source index wins. The vector is the index plus 64. The spurious vector 24 is shown when nothing is active.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A source is active only when (its pending bit OR its force bit) AND its level register is nonzero AND its mask bit is 0. The force bits have no write path and always hold 0.
- R2: Byte offsets 0x40 + n (n = 0..63) hold the 8-bit level of source n. A write loads bus_wdata[7:0]. A read returns the level in bits [7:0] with the upper bits zero. A nonzero level enables the source and a zero level disables it.
- R3: Among the active sources, the one with the numerically highest level wins. When levels are equal, the source with the highest index wins.
- R4: With a winner, cpu_vector equals the winner index plus 64 and cpu_level carries the winner's full 8-bit level. cpu_ipl always equals cpu_level[2:0].
- R5: With no active source, cpu_vector is 24 and cpu_level is 0.
- R6: Each pending bit takes the value of its input line on every clock edge. Pending reads as bits 63:32 at offset 0x00 and bits 31:0 at offset 0x04. Writes to 0x00 and 0x04 change nothing.
- R7: The mask reads and writes as bits 63:32 at offset 0x08 and bits 31:0 at offset 0x0C. A mask bit of 1 blocks its source.
- R8: A write to 0x1C sets the mask bit selected by bus_wdata[5:0], or sets all mask bits when bus_wdata[6] is 1. A write to 0x1D clears the selected bit, or clears all mask bits when bus_wdata[6] is 1.
- R9: A read at 0xE0 returns the current cpu_vector in bits [7:0]. Reads at 0xE1 to 0xE7 return 0, as do reads at any other unmapped offset. The force halves at 0x10 and 0x14 read as 0.
- R10: Writes to unmapped offsets and to the force offsets change no state. Every bus access, read or write, is acknowledged by bus_ack one clock after bus_sel is sampled. Read data is valid in that same cycle.
- R11: After reset, all mask bits are 1 and the pending bits, force bits and level registers are 0. cpu_vector is 24 and cpu_level is 0.
- R12: cpu_level and cpu_vector are registered. A register change shows at the outputs one clock after the write edge. An input line change shows by the second rising edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 64 | Level-sensitive request lines, one per source |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| bus_ack | output | 1 | Access acknowledge, one cycle after bus_sel |
| cpu_level | output | 8 | Level of the winning source, 0 when none |
| cpu_ipl | output | 3 | Processor priority level, low 3 bits of cpu_level |
| cpu_vector | output | 8 | Winning source index plus 64, or 24 when none |

## Verification
A corrupted level register, mask bit or pending bit shows up as a wrong cpu_vector or cpu_level. The arbitration output is registered, so the error appears within two clocks of the stimulus that exposes it. Because a wrong value only appears when the bad source would change the winner, the bench sweeps many random level, mask and request patterns and compares against a reference. It also includes directed ties and single-bit mask commands. Register readback through the bus shows mask and level damage directly, even when the affected source is not currently winning.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic [3:0] {
    RK_NONE,
    RK_PEND_HI,
    RK_PEND_LO,
    RK_MASK_HI,
    RK_MASK_LO,
    RK_FORCE_HI,
    RK_FORCE_LO,
    RK_MASK_SET,
    RK_MASK_CLR,
    RK_LEVEL,
    RK_SWACK
  } reg_kind_e;

  // Byte offsets; the level window is 0x40..0x7F (one byte per source).
  localparam logic [7:0] OFS_PEND_HI  = 8'h00;
  localparam logic [7:0] OFS_PEND_LO  = 8'h04;
  localparam logic [7:0] OFS_MASK_HI  = 8'h08;
  localparam logic [7:0] OFS_MASK_LO  = 8'h0C;
  localparam logic [7:0] OFS_FORCE_HI = 8'h10;
  localparam logic [7:0] OFS_FORCE_LO = 8'h14;
  localparam logic [7:0] OFS_MASK_SET = 8'h1C;
  localparam logic [7:0] OFS_MASK_CLR = 8'h1D;
  localparam logic [7:0] OFS_SWACK    = 8'hE0;

  function automatic reg_kind_e decode_ofs(input logic [7:0] ofs);
    reg_kind_e k;
    case (ofs)
      OFS_PEND_HI:  k = RK_PEND_HI;
      OFS_PEND_LO:  k = RK_PEND_LO;
      OFS_MASK_HI:  k = RK_MASK_HI;
      OFS_MASK_LO:  k = RK_MASK_LO;
      OFS_FORCE_HI: k = RK_FORCE_HI;
      OFS_FORCE_LO: k = RK_FORCE_LO;
      OFS_MASK_SET: k = RK_MASK_SET;
      OFS_MASK_CLR: k = RK_MASK_CLR;
      OFS_SWACK:    k = RK_SWACK;
      default:      k = (ofs[7:6] == 2'b01) ? RK_LEVEL : RK_NONE;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int LVL_W   = 8,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = $clog2(NUM_SRC),
  localparam int HI_W   = NUM_SRC - DATA_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_SRC-1:0]           irq_in,
  input  logic                         wr_en,
  input  reg_kind_e                    wr_kind,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [DATA_W-1:0]            wr_data,
  output logic [NUM_SRC-1:0]           pend_q,
  output logic [NUM_SRC-1:0]           mask_q,
  output logic [NUM_SRC-1:0][LVL_W-1:0] lvl_q,
  output logic [NUM_SRC-1:0]           enab
);

  // Named events for the assertions below.
  logic mask_all_set, mask_all_clr, mask_one_set, mask_one_clr;
  logic [IDX_W-1:0] cmd_idx;

  assign cmd_idx      = wr_data[IDX_W-1:0];
  assign mask_all_set = wr_en && wr_kind == RK_MASK_SET &&  wr_data[6];
  assign mask_one_set = wr_en && wr_kind == RK_MASK_SET && !wr_data[6];
  assign mask_all_clr = wr_en && wr_kind == RK_MASK_CLR &&  wr_data[6];
  assign mask_one_clr = wr_en && wr_kind == RK_MASK_CLR && !wr_data[6];

  // Pending bits mirror the request lines; software cannot write them.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= irq_in;
  end

  // Mask register: half writes plus byte set/clear commands.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
    end else if (wr_en) begin
      if (wr_kind == RK_MASK_HI)      mask_q[NUM_SRC-1:DATA_W] <= wr_data[HI_W-1:0];
      else if (wr_kind == RK_MASK_LO) mask_q[DATA_W-1:0]       <= wr_data;
      else if (mask_all_set)          mask_q                   <= '1;
      else if (mask_one_set)          mask_q[cmd_idx]          <= 1'b1;
      else if (mask_all_clr)          mask_q                   <= '0;
      else if (mask_one_clr)          mask_q[cmd_idx]          <= 1'b0;
    end
  end

  // Per-source level registers; a nonzero level doubles as the enable.
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_lvl
    logic hit;
    assign hit = wr_en && wr_kind == RK_LEVEL && wr_idx == IDX_W'(g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   lvl_q[g] <= '0;
      else if (hit) lvl_q[g] <= wr_data[LVL_W-1:0];
    end
    assign enab[g] = |lvl_q[g];
  end

  assert_pend_track_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> pend_q == $past(irq_in));

  assert_mask_all_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mask_all_set |=> mask_q == '1);

  assert_mask_all_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mask_all_clr |=> mask_q == '0);

  assert_mask_one_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mask_one_clr |=> !mask_q[$past(cmd_idx)]);

  assert_mask_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mask_q));

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NUM_SRC = 64,
  parameter int LVL_W   = 8,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]            active,
  input  logic [NUM_SRC-1:0][LVL_W-1:0] lvl,
  output logic                          win_valid,
  output logic [IDX_W-1:0]              win_idx,
  output logic [LVL_W-1:0]              win_lvl
);

  // Ascending scan with >= so that a later (higher) index takes a tie.
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_lvl   = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (active[i] && lvl[i] >= win_lvl) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(i);
        win_lvl   = lvl[i];
      end
    end
  end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_SRC  = 64,
  parameter int LVL_W    = 8,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter int VEC_W    = 8,
  parameter int IPL_W    = 3,
  parameter int VEC_BASE = 64,
  parameter int SPUR_VEC = 24,
  localparam int IDX_W   = $clog2(NUM_SRC),
  localparam int HI_W    = NUM_SRC - DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [63:0]        irq_in,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [7:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               bus_ack,
  output logic [7:0]         cpu_level,
  output logic [2:0]         cpu_ipl,
  output logic [7:0]         cpu_vector
);

  reg_kind_e kind;
  logic      wr_en;
  logic [NUM_SRC-1:0]            pend_q, mask_q, enab, force_q, active;
  logic [NUM_SRC-1:0][LVL_W-1:0] lvl_q;
  logic                          win_valid;
  logic [IDX_W-1:0]              win_idx;
  logic [LVL_W-1:0]              win_lvl;
  logic [VEC_W-1:0]              vec_next, vec_q;
  logic [LVL_W-1:0]              lvl_next, lvl_out_q;
  logic [DATA_W-1:0]             rd_next;

  function automatic logic [VEC_W-1:0] vec_of(input logic valid, input logic [IDX_W-1:0] idx);
    return valid ? VEC_W'(VEC_BASE) + VEC_W'(idx) : VEC_W'(SPUR_VEC);
  endfunction

  assign kind    = decode_ofs(bus_addr);
  assign wr_en   = bus_sel && bus_wr;
  assign force_q = '0;
  assign active  = (pend_q | force_q) & enab & ~mask_q;

  irq_regfile #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_in  (irq_in),
    .wr_en   (wr_en),
    .wr_kind (kind),
    .wr_idx  (bus_addr[IDX_W-1:0]),
    .wr_data (bus_wdata),
    .pend_q  (pend_q),
    .mask_q  (mask_q),
    .lvl_q   (lvl_q),
    .enab    (enab)
  );

  irq_arbiter #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_arb (
    .active    (active),
    .lvl       (lvl_q),
    .win_valid (win_valid),
    .win_idx   (win_idx),
    .win_lvl   (win_lvl)
  );

  assign vec_next = vec_of(win_valid, win_idx);
  assign lvl_next = win_valid ? win_lvl : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q     <= VEC_W'(SPUR_VEC);
      lvl_out_q <= '0;
    end else begin
      vec_q     <= vec_next;
      lvl_out_q <= lvl_next;
    end
  end

  assign cpu_vector = vec_q;
  assign cpu_level  = lvl_out_q;
  assign cpu_ipl    = lvl_out_q[IPL_W-1:0];

  // Read mux; anything not listed reads as zero.
  always_comb begin
    rd_next = '0;
    case (kind)
      RK_PEND_HI:  rd_next = DATA_W'(pend_q[NUM_SRC-1:DATA_W]);
      RK_PEND_LO:  rd_next = pend_q[DATA_W-1:0];
      RK_MASK_HI:  rd_next = DATA_W'(mask_q[NUM_SRC-1:DATA_W]);
      RK_MASK_LO:  rd_next = mask_q[DATA_W-1:0];
      RK_FORCE_HI: rd_next = DATA_W'(force_q[NUM_SRC-1:DATA_W]);
      RK_FORCE_LO: rd_next = force_q[DATA_W-1:0];
      RK_LEVEL:    rd_next = DATA_W'(lvl_q[bus_addr[IDX_W-1:0]]);
      RK_SWACK:    rd_next = DATA_W'(vec_q);
      default:     rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_ack   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ack   <= bus_sel;
      bus_rdata <= (bus_sel && !bus_wr) ? rd_next : '0;
    end
  end

  assert_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !win_valid |=> (cpu_vector == VEC_W'(SPUR_VEC) && cpu_level == '0));

  assert_winner_active_R1: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (active[win_idx] && win_lvl != '0));

  assert_vector_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_vector != VEC_W'(SPUR_VEC) |-> (cpu_vector >= VEC_W'(VEC_BASE) && cpu_level != '0));

  assert_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel |=> bus_ack);

  assert_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |=> cpu_level == $past(win_lvl));

endmodule

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq_in = '0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ack;
  logic [7:0]  cpu_level;
  logic [2:0]  cpu_ipl;
  logic [7:0]  cpu_vector;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  // Reference state
  logic [63:0] m_mask;
  logic [7:0]  m_lvl [64];

  always #10 clk = ~clk;

  irq_prio_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .cpu_level(cpu_level), .cpu_ipl(cpu_ipl), .cpu_vector(cpu_vector)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference winner: highest level, later index wins a tie (scan descending, strict >).
  function automatic int ref_winner(input logic [63:0] lines);
    int best = -1;
    int bl = 0;
    for (int i = 63; i >= 0; i--) begin
      if (lines[i] && !m_mask[i] && m_lvl[i] != 0 && int'(m_lvl[i]) > bl) begin
        bl = int'(m_lvl[i]);
        best = i;
      end
    end
    return best;
  endfunction

  function automatic logic [7:0] ref_vec(input logic [63:0] lines);
    int w = ref_winner(lines);
    return (w < 0) ? 8'd24 : 8'(w + 64);
  endfunction

  function automatic logic [7:0] ref_lvl(input logic [63:0] lines);
    int w = ref_winner(lines);
    return (w < 0) ? 8'd0 : m_lvl[w];
  endfunction

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    check("R10 write ack", 32'(bus_ack), 32'd1);
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
    check("R10 read ack", 32'(bus_ack), 32'd1);
  endtask

  task automatic set_level(input int n, input logic [7:0] v);
    bus_write(8'(8'h40 + n), {24'hABCDEF, v});
    m_lvl[n] = v;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic check_outputs(input string req);
    logic [31:0] rd;
    settle();
    check({req, " vector"}, 32'(cpu_vector), 32'(ref_vec(irq_in)));
    check({req, " level"},  32'(cpu_level),  32'(ref_lvl(irq_in)));
    check("R4 ipl", 32'(cpu_ipl), 32'(ref_lvl(irq_in) & 8'h7));
    bus_read(8'hE0, rd);
    check("R9 swack", rd, 32'(ref_vec(irq_in)));
  endtask

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd20240611));
    m_mask = '1;
    for (int i = 0; i < 64; i++) m_lvl[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R11 reset state
    check("R11 vector", 32'(cpu_vector), 32'd24);
    check("R11 level", 32'(cpu_level), 32'd0);
    bus_read(8'h08, rd); check("R11 mask hi", rd, 32'hFFFFFFFF);
    bus_read(8'h0C, rd); check("R11 mask lo", rd, 32'hFFFFFFFF);
    bus_read(8'h45, rd); check("R11 level reg", rd, 32'd0);

    // R6 pending follows lines, halves, writes ignored
    irq_in = 64'h1234_5678_9ABC_DEF0;
    @(negedge clk);
    bus_read(8'h00, rd); check("R6 pend hi", rd, 32'h12345678);
    bus_read(8'h04, rd); check("R6 pend lo", rd, 32'h9ABCDEF0);
    bus_write(8'h00, 32'h0); bus_write(8'h04, 32'h0);
    bus_read(8'h04, rd); check("R6 pend write ignored", rd, 32'h9ABCDEF0);
    // R5/R1: lines high but everything masked and disabled
    check_outputs("R5 masked");

    // R7 mask halves
    bus_write(8'h08, 32'h0F0F_0000); bus_write(8'h0C, 32'h0000_00F0);
    m_mask = 64'h0F0F0000_000000F0;
    bus_read(8'h08, rd); check("R7 mask hi", rd, 32'h0F0F0000);
    bus_read(8'h0C, rd); check("R7 mask lo", rd, 32'h000000F0);

    // R8 all-clear, then single set/clear
    bus_write(8'h1D, 32'h40); m_mask = '0;
    bus_read(8'h08, rd); check("R8 unmask all", rd, 32'h0);
    bus_write(8'h1C, 32'd37); m_mask[37] = 1;
    bus_read(8'h08, rd); check("R8 set one", rd, 32'h20);
    bus_write(8'h1C, 32'h40); m_mask = '1;
    bus_read(8'h0C, rd); check("R8 mask all", rd, 32'hFFFFFFFF);
    bus_write(8'h1D, 32'h40); m_mask = '0;

    // R2 level write/read, R1 enable by nonzero level
    irq_in = '0; irq_in[5] = 1; irq_in[9] = 1;
    check_outputs("R1 not enabled");
    set_level(5, 8'h03);
    bus_read(8'h45, rd); check("R2 level readback", rd, 32'h03);
    check_outputs("R4 single");
    // R3 tie: equal levels, higher index wins
    set_level(9, 8'h03);
    check_outputs("R3 tie");
    set_level(5, 8'h0E);
    check_outputs("R3 higher level");
    set_level(5, 8'h00);
    check_outputs("R2 disable by zero");
    bus_write(8'h1C, 32'd9); m_mask[9] = 1;
    check_outputs("R5 none active");

    // R12 latency: a line change is seen by the second edge
    bus_write(8'h1D, 32'd9); m_mask[9] = 0;
    settle();
    @(negedge clk); irq_in[9] = 0;
    @(posedge clk); @(posedge clk); #1;
    check("R12 latency vector", 32'(cpu_vector), 32'd24);

    // R9 unmapped and force reads, R10 unmapped writes
    bus_read(8'hE3, rd); check("R9 e3 zero", rd, 32'h0);
    bus_read(8'h10, rd); check("R9 force hi zero", rd, 32'h0);
    bus_write(8'h14, 32'hFFFFFFFF); bus_write(8'h20, 32'hFFFFFFFF);
    bus_read(8'h14, rd); check("R10 force write ignored", rd, 32'h0);
    bus_read(8'h0C, rd); check("R10 unmapped write ignored", rd, 32'h0);
    bus_read(8'h20, rd); check("R9 unmapped zero", rd, 32'h0);

    // Random phase
    for (int it = 0; it < 300; it++) begin
      int op = $urandom_range(0, 3);
      case (op)
        0: irq_in = {$urandom(), $urandom()};
        1: set_level($urandom_range(0, 63), 8'($urandom_range(0, 3) == 0 ? 0 : $urandom_range(1, 255)));
        2: begin
             logic [6:0] c = 7'($urandom_range(0, 63)) | (($urandom_range(0, 15) == 0) ? 7'h40 : 7'h0);
             bus_write(8'h1C, 32'(c));
             if (c[6]) m_mask = '1; else m_mask[c[5:0]] = 1;
           end
        default: begin
             logic [6:0] c = 7'($urandom_range(0, 63)) | (($urandom_range(0, 7) == 0) ? 7'h40 : 7'h0);
             bus_write(8'h1D, 32'(c));
             if (c[6]) m_mask = '0; else m_mask[c[5:0]] = 0;
           end
      endcase
      check_outputs("R3 random");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule